// File: doc/BRIEF.md
# Lane Permutation Crossbar

This unit rearranges a 64-lane vector operand before it reaches the lanes that consume it. For every destination lane it works out which source lane supplies the value, under a 9-bit control code. The code selects one of several patterns: a free permutation inside each group of four lanes, a shift or rotation inside each 16-lane row, a mirror of a row or of a half-row, or a broadcast of the last lane of an earlier row into the lanes above it.

Two 4-bit enable masks turn destination lanes off: one bit per 16-lane row, and one bit per position of a 4-lane group inside its row. When a source lane falls outside its row or is inactive in the execution mask, a single bound bit decides what happens. When it is set the lane is written with zero. When it is clear the lane is not written. A control code that names no pattern raises a flag and suppresses every write.

The result is registered. It appears one cycle after an input beat marked valid, with a per-lane write enable and a valid strobe.

Top module: `lperm_xbar`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high. The outputs are loaded only from beats with `in_valid` high.
- R2: Codes 0x000–0x0FF are group permutes. Destination lane L takes source lane (L with its low 2 bits cleared) OR the 2-bit field of the code that starts at bit 2×(L mod 4).
- R3: Codes 0x101–0x10F shift left by n = code[3:0]. With k = L mod 16, the source is L+n. When k+n > 15 the source is out of bounds.
- R4: Codes 0x111–0x11F shift right by n = code[3:0]. The source is L−n. When k < n the source is out of bounds.
- R5: Codes 0x121–0x12F rotate right by n = code[3:0]. The source is row base + ((k − n) mod 16).
- R6: Code 0x140 mirrors each row. Offset k takes its source from offset 15−k in the same row.
- R7: Code 0x141 mirrors each 8-lane half-row. Offset j within the half-row takes its source from offset 7−j.
- R8: Code 0x142 gives every lane above 15 the source (L AND 0x30)−1. Code 0x143 gives every lane above 31 the source (L AND 0x20)−1. Lanes at or below the threshold take their own lane as source.
- R9: A lane whose row-enable bit `row_en[L/16]` is clear, or whose bank-enable bit `bank_en[(L/4) mod 4]` is clear, has write enable 0. This takes priority over the bound rule.
- R10: An enabled lane whose source is out of bounds or has a clear `exec_mask` bit is written with zero when `bound_zero` is 1, and is not written when `bound_zero` is 0. Otherwise it is written with the source lane's value.
- R11: Every lane with write enable 0 presents its own input value on `out_data`.
- R12: Code 0x100, codes 0x110, 0x120 and 0x130–0x13F, and codes from 0x144 upward set `out_illegal` and clear every write enable.
- R13: While reset is high, `out_valid`, `out_illegal`, `out_we` and `out_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| ctl | input | 9 | Permutation control code |
| row_en | input | 4 | Per-row destination enable |
| bank_en | input | 4 | Per-group-position destination enable |
| bound_zero | input | 1 | 1: zero-fill lanes with a bad source; 0: leave them unwritten |
| exec_mask | input | 64 | Active source lanes |
| src_data | input | 2048 | 64 source values, lane L at bits [32L+31:32L] |
| out_valid | output | 1 | Result valid |
| out_data | output | 2048 | 64 permuted values |
| out_we | output | 64 | Per-lane write enable |
| out_illegal | output | 1 | Control code was not a defined pattern |

## Verification
The hardest case to reach from the ports is an enabled lane whose source is invalid for two different reasons at once: out of its row under a shift, and inactive in the execution mask. Each of these has to be seen under both settings of the bound bit, while the masks are gating other lanes in the same beat. The stimulus runs each shift pattern twice with sparse execution masks, once with the bound bit set and once clear. It then overlays row and bank masks on the same patterns, so that zero-fill, no-write and masked lanes all occur together in one result. A reference model in the bench predicts every lane, and a scoreboard compares it with the result.

// File: rtl/lperm_pkg.sv
package lperm_pkg;

    localparam int CTL_W = 9;

    typedef enum logic [3:0] {
        OP_GRP    = 4'd0,
        OP_SHL    = 4'd1,
        OP_SHR    = 4'd2,
        OP_ROR    = 4'd3,
        OP_MIR    = 4'd4,
        OP_HMIR   = 4'd5,
        OP_BC_ONE = 4'd6,
        OP_BC_TWO = 4'd7,
        OP_BAD    = 4'd8
    } perm_op_e;

    typedef struct packed {
        perm_op_e   op;
        logic [7:0] sel;
        logic [3:0] cnt;
    } perm_cmd_t;

    function automatic perm_cmd_t decode_ctl(input logic [CTL_W-1:0] code);
        perm_cmd_t c;
        c.sel = code[7:0];
        c.cnt = code[3:0];
        c.op  = OP_BAD;
        if (!code[8]) begin
            c.op = OP_GRP;
        end else begin
            case (code[7:4])
                4'h0: c.op = (code[3:0] != 4'h0) ? OP_SHL : OP_BAD;
                4'h1: c.op = (code[3:0] != 4'h0) ? OP_SHR : OP_BAD;
                4'h2: c.op = (code[3:0] != 4'h0) ? OP_ROR : OP_BAD;
                4'h4: begin
                    case (code[3:0])
                        4'h0:    c.op = OP_MIR;
                        4'h1:    c.op = OP_HMIR;
                        4'h2:    c.op = OP_BC_ONE;
                        4'h3:    c.op = OP_BC_TWO;
                        default: c.op = OP_BAD;
                    endcase
                end
                default: c.op = OP_BAD;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/lperm_lane_map.sv
module lperm_lane_map
    import lperm_pkg::*;
#(
    parameter int LANES = 64,
    parameter int ROW   = 16,
    parameter int QUAD  = 4,
    parameter int LANE  = 0,
    localparam int LW   = $clog2(LANES)
) (
    input  perm_cmd_t        cmd,
    output logic [LW-1:0]    src_idx,
    output logic             oob
);
    localparam int OFF   = LANE % ROW;
    localparam int BASE  = LANE - OFF;
    localparam int HALF  = ROW / 2;
    localparam int HOFF  = LANE % HALF;
    localparam int QBASE = LANE - (LANE % QUAD);
    localparam int QPOS  = LANE % QUAD;

    int src;
    int t;

    always_comb begin
        src = LANE;
        t   = 0;
        oob = 1'b0;
        case (cmd.op)
            OP_GRP: begin
                src = QBASE + int'((cmd.sel >> (2 * QPOS)) & 8'd3);
            end
            OP_SHL: begin
                t = OFF + int'(cmd.cnt);
                if (t > ROW - 1) oob = 1'b1;
                else             src = BASE + t;
            end
            OP_SHR: begin
                t = OFF - int'(cmd.cnt);
                if (t < 0) oob = 1'b1;
                else       src = BASE + t;
            end
            OP_ROR: begin
                t   = (OFF - int'(cmd.cnt) + ROW) % ROW;
                src = BASE + t;
            end
            OP_MIR: begin
                src = BASE + (ROW - 1 - OFF);
            end
            OP_HMIR: begin
                src = LANE - HOFF + (HALF - 1 - HOFF);
            end
            OP_BC_ONE: begin
                if (LANE > ROW - 1) src = BASE - 1;
            end
            OP_BC_TWO: begin
                if (LANE > 2 * ROW - 1) src = (LANE / (2 * ROW)) * (2 * ROW) - 1;
            end
            default: begin
                src = LANE;
            end
        endcase
        src_idx = src[LW-1:0];
    end

endmodule

// File: rtl/lperm_lane_sel.sv
module lperm_lane_sel #(
    parameter int LANES = 64,
    parameter int DW    = 32,
    parameter int LANE  = 0,
    localparam int LW   = $clog2(LANES)
) (
    input  logic [LANES*DW-1:0] src_flat,
    input  logic [LANES-1:0]    exec_mask,
    input  logic [LW-1:0]       src_idx,
    input  logic                oob,
    input  logic                lane_on,
    input  logic                illegal,
    input  logic                bound_zero,
    output logic [DW-1:0]       data,
    output logic                we
);
    logic [DW-1:0] own_val;
    logic [DW-1:0] pick_val;
    logic          src_bad;

    always_comb begin
        own_val  = src_flat[LANE*DW +: DW];
        pick_val = src_flat[int'(src_idx)*DW +: DW];
        src_bad  = oob || !exec_mask[src_idx];
        we       = 1'b0;
        data     = own_val;
        if (illegal || !lane_on) begin
            we   = 1'b0;
            data = own_val;
        end else if (src_bad) begin
            we   = bound_zero;
            data = bound_zero ? '0 : own_val;
        end else begin
            we   = 1'b1;
            data = pick_val;
        end
    end

endmodule

// File: rtl/lperm_xbar.sv
module lperm_xbar
    import lperm_pkg::*;
#(
    parameter int LANES = 64,
    parameter int DW    = 32,
    parameter int ROW   = 16,
    parameter int QUAD  = 4,
    localparam int ROWS  = LANES / ROW,
    localparam int BANKS = ROW / QUAD,
    localparam int LW    = $clog2(LANES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [CTL_W-1:0]     ctl,
    input  logic [ROWS-1:0]      row_en,
    input  logic [BANKS-1:0]     bank_en,
    input  logic                 bound_zero,
    input  logic [LANES-1:0]     exec_mask,
    input  logic [LANES*DW-1:0]  src_data,
    output logic                 out_valid,
    output logic [LANES*DW-1:0]  out_data,
    output logic [LANES-1:0]     out_we,
    output logic                 out_illegal
);
    perm_cmd_t            cmd;
    logic                 illegal;
    logic [LANES*DW-1:0]  nxt_data;
    logic [LANES-1:0]     nxt_we;

    always_comb begin
        cmd     = decode_ctl(ctl);
        illegal = (cmd.op == OP_BAD);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] idx;
        logic          oob;
        logic          on;

        assign on = row_en[g / ROW] && bank_en[(g / QUAD) % BANKS];

        lperm_lane_map #(
            .LANES(LANES), .ROW(ROW), .QUAD(QUAD), .LANE(g)
        ) map_i (
            .cmd     (cmd),
            .src_idx (idx),
            .oob     (oob)
        );

        lperm_lane_sel #(
            .LANES(LANES), .DW(DW), .LANE(g)
        ) sel_i (
            .src_flat   (src_data),
            .exec_mask  (exec_mask),
            .src_idx    (idx),
            .oob        (oob),
            .lane_on    (on),
            .illegal    (illegal),
            .bound_zero (bound_zero),
            .data       (nxt_data[g*DW +: DW]),
            .we         (nxt_we[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_we      <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data    <= nxt_data;
                out_we      <= nxt_we;
                out_illegal <= illegal;
            end
        end
    end

endmodule

// File: rtl/lperm_xbar_chk.sv
module lperm_xbar_chk #(
    parameter int LANES = 64,
    parameter int DW    = 32,
    parameter int ROW   = 16,
    parameter int QUAD  = 4,
    localparam int ROWS  = LANES / ROW,
    localparam int BANKS = ROW / QUAD
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [8:0]          ctl,
    input logic [ROWS-1:0]     row_en,
    input logic [BANKS-1:0]    bank_en,
    input logic [LANES-1:0]    exec_mask,
    input logic [LANES*DW-1:0] src_data,
    input logic                out_valid,
    input logic [LANES*DW-1:0] out_data,
    input logic [LANES-1:0]    out_we,
    input logic                out_illegal
);
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_drop_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_illegal_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (out_we == '0));

    p_row_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !row_en[0]) |=> (out_we[ROW-1:0] == '0));

    p_bank_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !bank_en[0]) |=> (!out_we[0] && !out_we[ROW]));

    p_hold_own_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_we[0] || out_data[DW-1:0] == $past(src_data[DW-1:0])));

    p_mirror_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl == 9'h140 && row_en[0] && bank_en[0] && exec_mask[ROW-1])
        |=> (out_we[0] && out_data[DW-1:0] == $past(src_data[ROW*DW-1 -: DW])));

endmodule

bind lperm_xbar lperm_xbar_chk #(
    .LANES(LANES), .DW(DW), .ROW(ROW), .QUAD(QUAD)
) chk_i (.*);

// File: tb/lperm_xbar_tb_top.sv
module lperm_xbar_tb_top;
    localparam int LANES = 64;
    localparam int DW    = 32;

    typedef struct {
        logic [LANES*DW-1:0] data;
        logic [LANES-1:0]    we;
        logic                ill;
        string               tag;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst;
    logic                 in_valid;
    logic [8:0]           ctl;
    logic [3:0]           row_en;
    logic [3:0]           bank_en;
    logic                 bound_zero;
    logic [LANES-1:0]     exec_mask;
    logic [LANES*DW-1:0]  src_data;
    logic                 out_valid;
    logic [LANES*DW-1:0]  out_data;
    logic [LANES-1:0]     out_we;
    logic                 out_illegal;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    lperm_xbar dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .ctl(ctl),
        .row_en(row_en), .bank_en(bank_en), .bound_zero(bound_zero),
        .exec_mask(exec_mask), .src_data(src_data),
        .out_valid(out_valid), .out_data(out_data), .out_we(out_we),
        .out_illegal(out_illegal)
    );

    function automatic void model(
        input  logic [8:0]          c,
        input  logic [3:0]          rm,
        input  logic [3:0]          bm,
        input  logic                bz,
        input  logic [LANES-1:0]    ex,
        input  logic [LANES*DW-1:0] sv,
        output logic [LANES*DW-1:0] d,
        output logic [LANES-1:0]    w,
        output logic                il);
        int ci;
        ci = int'(c);
        il = !(ci <= 'hFF || (ci >= 'h101 && ci <= 'h10F) || (ci >= 'h111 && ci <= 'h11F)
               || (ci >= 'h121 && ci <= 'h12F) || (ci >= 'h140 && ci <= 'h143));
        for (int l = 0; l < LANES; l++) begin
            int off, n, s;
            bit bad;
            off = l & 15; n = ci & 15; s = l; bad = 0;
            if (ci <= 'hFF)                     s = (l & ~3) | ((ci >> (2 * (l & 3))) & 3);
            else if (ci >= 'h101 && ci <= 'h10F) begin if (off + n > 15) bad = 1; else s = l + n; end
            else if (ci >= 'h111 && ci <= 'h11F) begin if (off < n) bad = 1; else s = l - n; end
            else if (ci >= 'h121 && ci <= 'h12F) s = (l & 48) | ((off - n) & 15);
            else if (ci == 'h140)               s = (l & 48) | (15 - off);
            else if (ci == 'h141)               s = (l & 56) | (7 - (l & 7));
            else if (ci == 'h142)               begin if (l > 15) s = (l & 48) - 1; end
            else if (ci == 'h143)               begin if (l > 31) s = (l & 32) - 1; end
            if (il || !rm[l >> 4] || !bm[(l >> 2) & 3]) begin
                w[l] = 0; d[l*DW +: DW] = sv[l*DW +: DW];
            end else if (bad || !ex[s]) begin
                w[l] = bz; d[l*DW +: DW] = bz ? '0 : sv[l*DW +: DW];
            end else begin
                w[l] = 1; d[l*DW +: DW] = sv[s*DW +: DW];
            end
        end
    endfunction

    function automatic logic [LANES*DW-1:0] make_src(input int seed);
        logic [LANES*DW-1:0] v;
        for (int l = 0; l < LANES; l++)
            v[l*DW +: DW] = 32'hA000_0000 | (32'(seed & 255) << 16) | 32'(l + 1);
        return v;
    endfunction

    task automatic drive(input logic [8:0] c, input logic [3:0] rm, input logic [3:0] bm,
                         input logic bz, input logic [LANES-1:0] ex, input int seed,
                         input string tag);
        exp_t e;
        logic [LANES*DW-1:0] sv;
        sv = make_src(seed);
        @(negedge clk);
        in_valid = 1'b1; ctl = c; row_en = rm; bank_en = bm;
        bound_zero = bz; exec_mask = ex; src_data = sv;
        model(c, rm, bm, bz, ex, sv, e.data, e.we, e.ill);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            exp_t e;
            if (sb.size() == 0) begin
                n_checks++; n_errors++;
                $display("FAIL R1: result with no pending beat, actual out_valid=1 expected 0");
            end else begin
                e = sb.pop_front();
                n_checks++;
                if (out_we !== e.we) begin
                    n_errors++;
                    $display("FAIL %s: out_we actual %h expected %h", e.tag, out_we, e.we);
                end
                n_checks++;
                if (out_data !== e.data) begin
                    n_errors++;
                    for (int l = 0; l < LANES; l++)
                        if (out_data[l*DW +: DW] !== e.data[l*DW +: DW]) begin
                            $display("FAIL %s: lane %0d data actual %h expected %h",
                                     e.tag, l, out_data[l*DW +: DW], e.data[l*DW +: DW]);
                            break;
                        end
                end
                n_checks++;
                if (out_illegal !== e.ill) begin
                    n_errors++;
                    $display("FAIL %s: out_illegal actual %b expected %b", e.tag, out_illegal, e.ill);
                end
            end
        end
    end

    initial begin
        #200000;
        n_checks++; n_errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [LANES-1:0] all1, alt, sparse;
        all1   = '1;
        alt    = {32{2'b01}};
        sparse = 64'hF0F0_3C3C_FF00_A5A5;
        rst = 1'b1; in_valid = 1'b0; ctl = '0; row_en = '0; bank_en = '0;
        bound_zero = 1'b0; exec_mask = '0; src_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_we !== '0 || out_illegal !== 1'b0 || out_data !== '0) begin
            n_errors++;
            $display("FAIL R13: reset outputs actual v=%b we=%h il=%b expected all zero",
                     out_valid, out_we, out_illegal);
        end
        rst = 1'b0;

        drive(9'h01B, 4'hF, 4'hF, 1'b0, all1, 1, "R2 grp 0x1B");
        drive(9'h0E4, 4'hF, 4'hF, 1'b0, all1, 2, "R2 grp 0xE4");
        drive(9'h0C6, 4'hF, 4'hF, 1'b1, alt,  3, "R2 grp masked exec");
        drive(9'h101, 4'hF, 4'hF, 1'b1, all1, 4, "R3 shl 1 zero");
        drive(9'h10F, 4'hF, 4'hF, 1'b0, all1, 5, "R3 shl 15 keep");
        drive(9'h113, 4'hF, 4'hF, 1'b1, sparse, 6, "R4 shr 3 zero");
        drive(9'h113, 4'hF, 4'hF, 1'b0, sparse, 7, "R4 shr 3 keep");
        drive(9'h125, 4'hF, 4'hF, 1'b0, all1, 8, "R5 ror 5");
        drive(9'h12F, 4'hF, 4'hF, 1'b1, alt,  9, "R5 ror 15");
        drive(9'h140, 4'hF, 4'hF, 1'b0, all1, 10, "R6 mirror");
        drive(9'h141, 4'hF, 4'hF, 1'b0, all1, 11, "R7 half mirror");
        drive(9'h142, 4'hF, 4'hF, 1'b0, all1, 12, "R8 bcast row");
        drive(9'h143, 4'hF, 4'hF, 1'b1, sparse, 13, "R8 bcast half");
        idle();
        idle();
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_errors++;
            $display("FAIL R1: out_valid after idle actual %b expected 0", out_valid);
        end
        drive(9'h107, 4'h5, 4'hF, 1'b1, sparse, 14, "R9 row mask");
        drive(9'h117, 4'hF, 4'h6, 1'b1, sparse, 15, "R9 bank mask");
        drive(9'h140, 4'hA, 4'h9, 1'b0, alt,    16, "R10 masks+keep");
        drive(9'h10C, 4'hE, 4'hB, 1'b0, sparse, 17, "R11 own value");
        drive(9'h100, 4'hF, 4'hF, 1'b1, all1, 18, "R12 code 0x100");
        drive(9'h13F, 4'hF, 4'hF, 1'b1, all1, 19, "R12 code 0x13F");
        drive(9'h144, 4'hF, 4'hF, 1'b1, all1, 20, "R12 code 0x144");
        drive(9'h1FF, 4'hF, 4'hF, 1'b0, all1, 21, "R12 code 0x1FF");
        drive(9'h120, 4'hF, 4'hF, 1'b1, all1, 22, "R12 code 0x120");
        drive(9'h0FF, 4'hF, 4'hF, 1'b1, all1, 23, "R2 grp top code");
        for (int i = 0; i < 16; i++)
            drive(9'(9'h100 | (i[1:0] << 4) | 9'(i)), 4'(i), 4'(15 - i), i[0],
                  (i[1] ? sparse : alt), 30 + i, "R10 sweep");
        idle();
        idle();
        idle();
        n_checks++;
        if (sb.size() != 0) begin
            n_errors++;
            $display("FAIL R1: pending beats actual %0d expected 0", sb.size());
        end
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule